// File: doc/BRIEF.md
# Four-Lane Marker Alignment and Deskew Receiver

This block sits on the receive side of a striped multi-lane link. It takes four physical lanes of 66-bit blocks. The lanes can arrive in any order and with different delays. Each lane hunts for periodic alignment markers on its own. Once it has locked, the marker tells it which virtual lane it carries. A small FIFO on each lane soaks up the delay difference between lanes.

A deskew controller throws away blocks ahead of the first marker on each lane. It then holds the early lanes until every lane shows a marker at its FIFO head, and releases all four together. From that point the lanes are read in lockstep. The four blocks of each read are placed in virtual-lane order and leave the block as one 256-bit payload word plus an 8-bit header word. Marker blocks are consumed and never leave the block.

Block lock on sync headers, descrambling and decoding happen upstream or downstream and are not part of this block.

Top module: `lane_deskew_align`

## Requirements
- R1: A valid marker has all of the following fields:
  - header 2'b10
  - payload bits [7:0] equal to 8'hC3
  - bits [15:8] holding the virtual lane number, which must be below the lane count
  - bits [23:16] holding the bitwise inverse of that number
  - bits [63:24] zero

  A block that breaks any of these fields never counts as a marker, so a stream carrying only such blocks never reaches `aligned`.
- R2: A lane locks only after seeing two valid markers with the same lane number exactly PERIOD blocks apart. `aligned` therefore stays low for the first PERIOD input cycles after reset.
- R3: A locked lane drops lock on the fourth consecutive marker slot that holds no matching marker. Three missing slots in a row leave `aligned` high.
- R4: Within lane p, input block p occupies `in_blk[66p+65:66p]`, and within each block bits [65:64] are the header. Skews of 0 to 20 blocks between lanes are removed, so all four lanes release the blocks of the same stripe position in the same cycle, and the lanes then advance in lockstep.
- R5: Output slot v holds the block of virtual lane v, whatever physical lane carried it: payload in `out_data[64v+63:64v]` and header in `out_hdr[2v+1:2v]`.
- R6: Marker blocks are removed. While aligned, any PERIOD consecutive cycles contain exactly PERIOD-1 `out_valid` cycles, and no output slot ever holds a marker.
- R7: `out_valid` is high only while `aligned` is high. `aligned` is high only while all four lanes are locked and deskewed. Loss of lock on any lane clears both.
- R8: If the lanes are skewed by more than the FIFO depth allows, a FIFO overflows. The block then pulses `err` and restarts alignment, and `aligned` never rises.
- R9: If two locked lanes report the same virtual lane number, the block pulses `err` and does not align while the duplicate remains.
- R10: After synchronous reset, `out_valid`, `aligned` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One block per lane is present on `in_blk` |
| in_blk | input | 264 | Four 66-bit lane blocks, physical lane p at [66p+65:66p] |
| out_valid | output | 1 | An aligned four-block group is on the outputs |
| out_data | output | 256 | Payloads in virtual-lane order |
| out_hdr | output | 8 | Sync headers in virtual-lane order |
| aligned | output | 1 | All lanes locked and deskewed |
| err | output | 1 | One-cycle pulse on overflow, duplicate lane number or marker misalignment |

## Verification
Random lane permutations combined with skews of up to 20 blocks catch two kinds of fault: a remap that picks the wrong physical lane, which shows up as a foreign lane tag in a slot, and a deskew that releases lanes early, which shows up as mixed stripe indices in one word.

Counting valid cycles over one marker period catches a design that forwards markers or drops one data block too many.

Stopping markers after alignment exposes lock hysteresis that is too eager (dropping after three missing slots) or too lax (never dropping).

Corrupt markers, a duplicated lane number and a skew of 40 blocks each have to end without alignment; a design that skipped the matching check would align anyway or stay silent on `err`.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam int BLK_W = 66;
  localparam int PAY_W = 64;
  localparam logic [1:0] HDR_CTRL = 2'b10;
  localparam logic [7:0] MRK_TAG  = 8'hC3;

  // Structural marker test; the lane-range check lives in the lane logic.
  function automatic logic mark_ok(input logic [BLK_W-1:0] b);
    return (b[65:64] == HDR_CTRL) && (b[7:0] == MRK_TAG) &&
           (b[23:16] == ~b[15:8]) && (b[63:24] == '0);
  endfunction
endpackage

// File: rtl/lane_marker_lock.sv
module lane_marker_lock
  import deskew_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int PERIOD  = 64,
  parameter int BAD_LIM = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       blk_valid,
  input  logic [BLK_W-1:0]           blk,
  output logic                       locked,
  output logic [$clog2(LANES)-1:0]   vl_id
);
  localparam int IDW = $clog2(LANES);
  localparam int CW  = $clog2(PERIOD);
  localparam int MW  = $clog2(BAD_LIM + 1);

  typedef enum logic [1:0] {S_SEARCH, S_CONFIRM, S_LOCK} st_t;
  st_t            st;
  logic [CW-1:0]  cnt;
  logic [MW-1:0]  miss;
  logic [IDW-1:0] id_q;

  logic mk, slot, match;
  assign mk    = mark_ok(blk) && (blk[15:8] < 8'(LANES));
  assign slot  = (cnt == CW'(PERIOD - 1));
  assign match = mk && (blk[8 +: IDW] == id_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_SEARCH;
      cnt  <= '0;
      miss <= '0;
      id_q <= '0;
    end else if (blk_valid) begin
      cnt <= slot ? '0 : cnt + 1'b1;
      case (st)
        S_SEARCH: if (mk) begin
          st   <= S_CONFIRM;
          id_q <= blk[8 +: IDW];
          cnt  <= '0;
        end
        S_CONFIRM: if (slot) begin
          st   <= match ? S_LOCK : S_SEARCH;
          miss <= '0;
        end
        default: if (slot) begin
          if (match) miss <= '0;
          else if (miss == MW'(BAD_LIM - 1)) st <= S_SEARCH;
          else miss <= miss + 1'b1;
        end
      endcase
    end
  end

  assign locked = (st == S_LOCK);
  assign vl_id  = id_q;

  // R2: lock is only ever gained on a cycle that carried a valid marker
  p_lock_on_marker_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(blk_valid && mk));
  // R3: a locked lane keeps its lane number until it leaves lock
  p_id_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(vl_id));
endmodule

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int W     = 66,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp, count;

  assign count = wp - rp;
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr && !full) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr && !full) wp <= wp + 1'b1;
      if (rd && !empty) rp <= rp + 1'b1;
    end
  end

  // R4: the deskew controller never pops an empty lane
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    rd |-> !empty);
  // R8: occupancy never exceeds the configured depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/lane_deskew_align.sv
module lane_deskew_align
  import deskew_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int PERIOD  = 64,
  parameter int DEPTH   = 32,
  parameter int BAD_LIM = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [LANES*BLK_W-1:0]   in_blk,
  output logic                     out_valid,
  output logic [LANES*PAY_W-1:0]   out_data,
  output logic [LANES*2-1:0]       out_hdr,
  output logic                     aligned,
  output logic                     err
);
  localparam int IDW = $clog2(LANES);

  typedef enum logic {A_HUNT, A_RUN} ast_t;
  ast_t st;

  logic [LANES-1:0] locked, emp, ne, full, head_mk, pop;
  logic [IDW-1:0]   vl_id [LANES];
  logic [BLK_W-1:0] head  [LANES];
  logic all_locked, all_ne, dup, dup_q, ovf, go_align, misalign;
  logic err_cond, flush, step_all, emit;

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    lane_marker_lock #(.LANES(LANES), .PERIOD(PERIOD), .BAD_LIM(BAD_LIM)) u_lock (
      .clk(clk), .rst(rst), .blk_valid(in_valid),
      .blk(in_blk[p*BLK_W +: BLK_W]),
      .locked(locked[p]), .vl_id(vl_id[p])
    );
    lane_fifo #(.W(BLK_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .flush(flush),
      .wr(in_valid & all_locked & ~flush),
      .wdata(in_blk[p*BLK_W +: BLK_W]),
      .rd(pop[p]), .rdata(head[p]), .empty(emp[p]), .full(full[p])
    );
    assign ne[p]      = ~emp[p];
    assign head_mk[p] = mark_ok(head[p]);
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (vl_id[i] == vl_id[j]) dup = 1'b1;
  end

  assign all_locked = &locked;
  assign all_ne     = &ne;
  assign ovf        = in_valid & all_locked & (|full);
  assign go_align   = (st == A_HUNT) & all_locked & ~dup & (&(ne & head_mk));
  assign misalign   = (st == A_RUN) & all_ne & (|head_mk) & ~(&head_mk);
  assign err_cond   = ovf | misalign | (all_locked & dup & ~dup_q);
  assign flush      = err_cond | ~all_locked | dup;
  assign step_all   = (st == A_RUN) & all_ne & ~misalign;
  assign emit       = step_all & ~(|head_mk) & ~flush;

  always_comb begin
    if (flush)             pop = '0;
    else if (st == A_HUNT) pop = (ne & ~head_mk) | {LANES{go_align}};
    else                   pop = {LANES{step_all}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= A_HUNT;
      out_valid <= 1'b0;
      err       <= 1'b0;
      dup_q     <= 1'b0;
    end else begin
      err       <= err_cond;
      dup_q     <= all_locked & dup;
      out_valid <= emit;
      if (flush)         st <= A_HUNT;
      else if (go_align) st <= A_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      for (int v = 0; v < LANES; v++)
        for (int p = 0; p < LANES; p++)
          if (vl_id[p] == IDW'(v)) begin
            out_data[v*PAY_W +: PAY_W] <= head[p][PAY_W-1:0];
            out_hdr[v*2 +: 2]          <= head[p][PAY_W +: 2];
          end
    end
  end

  assign aligned = (st == A_RUN);

  logic out_mk;
  always_comb begin
    out_mk = 1'b0;
    for (int v = 0; v < LANES; v++)
      if (mark_ok({out_hdr[v*2 +: 2], out_data[v*PAY_W +: PAY_W]})) out_mk = 1'b1;
  end

  // R7: data only while aligned, and alignment only after all lanes locked
  p_valid_needs_align_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> aligned);
  p_align_needs_lock_r7: assert property (@(posedge clk) disable iff (rst)
    aligned |-> $past(all_locked));
  // R4: once aligned, lanes advance together or not at all
  p_lockstep_r4: assert property (@(posedge clk) disable iff (rst)
    aligned |-> (pop == '0 || (&pop)));
  // R6: markers never leave the block
  p_no_marker_out_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_mk);
  // R8: an error always coincides with loss of alignment
  p_err_breaks_align_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> !aligned);
endmodule

// File: tb/sim_lane_deskew_align.sv
module sim_lane_deskew_align;
  localparam int L = 4;
  localparam int P = 64;
  localparam int D = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [L*66-1:0] in_blk = '0;
  logic out_valid, aligned, err;
  logic [L*64-1:0] out_data;
  logic [L*2-1:0] out_hdr;

  lane_deskew_align #(.LANES(L), .PERIOD(P), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_blk(in_blk),
    .out_valid(out_valid), .out_data(out_data), .out_hdr(out_hdr),
    .aligned(aligned), .err(err)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc;
  int perm [L];
  int skew [L];
  bit kill = 0, badmark = 0, sb_on = 1, synced = 0;
  int tk = 0;
  int q [$];
  int err_cnt, vcnt, ever_aligned, early_align, compared;

  function automatic logic [65:0] vblk(int v, int t);
    if (t < 0) return {2'b01, 64'h0};
    if ((t % P == 0) && !(kill && t >= tk)) begin
      if (badmark) return {2'b10, 40'h0, 8'(v), 8'(v), 8'hC3};
      return {2'b10, 40'h0, ~8'(v), 8'(v), 8'hC3};
    end
    return {2'b01, 8'(v), 24'h5A5A5A, 32'(t)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic monitor();
    logic [255:0] ed;
    logic [7:0] eh;
    logic [65:0] b;
    int t;
    if (err) err_cnt++;
    if (out_valid) vcnt++;
    if (aligned) ever_aligned = 1;
    if (aligned && cyc < P) early_align = 1;
    if (out_valid && sb_on) begin
      if (!synced) begin
        while (q.size() > 0 && q[0] < int'(out_data[31:0])) void'(q.pop_front());
        synced = 1;
      end
      if (q.size() == 0) chk(0, "R4 R5 queue empty", out_data, '0);
      else begin
        t = q.pop_front();
        for (int v = 0; v < L; v++) begin
          b = vblk(v, t);
          ed[v*64 +: 64] = b[63:0];
          eh[v*2 +: 2] = b[65:64];
        end
        compared++;
        chk(out_data == ed && out_hdr == eh, "R4 R5 R6 group", {out_hdr, out_data[247:0]}, {eh, ed[247:0]});
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    monitor();
    cyc++;
    for (int p = 0; p < L; p++) in_blk[p*66 +: 66] = vblk(perm[p], cyc - skew[p]);
    in_valid = 1'b1;
    if (cyc >= 0 && (cyc % P) != 0) q.push_back(cyc);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc = -4;
    q.delete();
    synced = 0; kill = 0; sb_on = 1;
    err_cnt = 0; vcnt = 0; ever_aligned = 0; early_align = 0; compared = 0;
    repeat (3) step();
    chk(out_valid == 0 && aligned == 0 && err == 0, "R10 reset state",
        {out_valid, aligned, err}, '0);
    rst = 1'b0;
  endtask

  task automatic normal_trial();
    do_reset();
    repeat (8 * P) step();
    chk(early_align == 0, "R2 no align before second marker", early_align, 0);
    chk(aligned == 1, "R4 aligned after deskew", aligned, 1);
    chk(err_cnt == 0, "R8 R9 no error on clean lanes", err_cnt, 0);
    chk(compared > 0, "R5 outputs compared", compared, 1);
    vcnt = 0;
    repeat (P) step();
    chk(vcnt == P - 1, "R6 marker removal count", vcnt, P - 1);
  endtask

  task automatic shuffle();
    int j, tmp;
    for (int i = 0; i < L; i++) perm[i] = i;
    for (int i = L - 1; i > 0; i--) begin
      j = $urandom_range(0, i);
      tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
    end
    for (int i = 0; i < L; i++) skew[i] = $urandom_range(0, 20);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    perm = '{2, 0, 3, 1};
    skew = '{0, 20, 7, 13};
    normal_trial();

    for (int k = 0; k < 3; k++) begin
      shuffle();
      normal_trial();
    end

    // R3 and R7: markers stop after alignment
    sb_on = 0;
    tk = ((cyc / P) + 1) * P;
    kill = 1;
    while (cyc < tk + 3 * P - 1) step();
    chk(aligned == 1, "R3 still aligned after three missing slots", aligned, 1);
    while (cyc < tk + 3 * P + 40) step();
    chk(aligned == 0, "R3 lock dropped after four missing slots", aligned, 0);
    chk(out_valid == 0, "R7 no valid without alignment", out_valid, 0);

    // R1: corrupted check byte never aligns
    perm = '{0, 1, 2, 3};
    skew = '{0, 0, 0, 0};
    badmark = 1;
    do_reset();
    repeat (5 * P) step();
    chk(ever_aligned == 0, "R1 bad marker rejected", ever_aligned, 0);
    badmark = 0;

    // R9: duplicate virtual lane number
    perm = '{0, 1, 1, 3};
    skew = '{3, 0, 5, 9};
    do_reset();
    repeat (5 * P) step();
    chk(err_cnt > 0, "R9 err on duplicate lane", err_cnt, 1);
    chk(ever_aligned == 0, "R9 no alignment with duplicate", ever_aligned, 0);

    // R8: skew beyond FIFO depth
    perm = '{3, 2, 1, 0};
    skew = '{0, 40, 10, 5};
    do_reset();
    repeat (6 * P) step();
    chk(err_cnt > 0, "R8 err on excessive skew", err_cnt, 1);
    chk(ever_aligned == 0, "R8 no alignment on excessive skew", ever_aligned, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule